// File: doc/BRIEF.md
# Three-Channel Timer Input Capture

This block timestamps edges on three timer input pins. Every clock it samples the pins and compares each with its value at the previous clock. A channel fires when its pin has changed and the change matches that channel's edge selection. When it fires, the block copies the free-running 16-bit timer count into the channel's capture register and sets the channel's flag. Software selects the edges, reads the captured counts and clears the flags over a byte-wide register bus. An interrupt request is raised while any flag is set together with its enable bit.

Pin bit i always goes to flag bit i and to edge field i. The channel names count the other way, though: pin 0 is capture channel 3 and pin 2 is capture channel 1. Everywhere below, channels are indexed by pin bit.

Top module: `icap_unit`

## Requirements
- R1: While reset is asserted and just after it is released, the edge-control, flag, enable and capture registers all read zero and `irq` is low.
- R2: The edge-control register is at address 0, and pin i takes its 2-bit code from bits [2i+1:2i]. Code 0 never captures, 1 captures a 0-to-1 change, 2 captures a 1-to-0 change and 3 captures either. Bits [7:6] read as zero.
- R3: A capture needs the pin's level to differ from its level at the previous clock. A pin held steady never captures, whatever its code.
- R4: On a capture, the channel's register takes the `timer_cnt` value present at the clock edge where the pin's new level is first seen.
- R5: The flag register is at address 1. A capture on pin i sets bit i, captures on other pins leave bit i alone, and bits [7:3] read as zero.
- R6: Writing address 1 clears every flag bit written as one and leaves every bit written as zero. If a capture on a channel happens in the same cycle as a clear of that channel's flag, the flag ends up set.
- R7: The enable register is at address 2, in bits [2:0]. `irq` is high exactly when some flag bit and the enable bit at the same position are both one, and it follows register changes with no extra delay.
- R8: The capture register of pin i reads at address 4+2i (low byte) and 5+2i (high byte). Bus writes to these addresses have no effect.
- R9: Address 3 and addresses 10 to 15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; zero when `bus_sel` is low |
| pin_in | input | 3 | Capture pins, already synchronous to `clk` |
| timer_cnt | input | 16 | Free-running timer count |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches every cycle for the following. A capture must only follow a real change on its pin. A capture must load the timer value from that edge and set the flag. A flag must change only by a capture or by a one-to-clear write. A capture register must hold its value between captures. A rising `irq` must be explained by a capture or by a write to the enable register. What a property cannot show is left to the bench scenarios: that the edge code chosen for each pin is actually obeyed, the byte layout of the registers, the set-over-clear priority as seen through reads, and that writes to read-only or unmapped addresses do nothing. For this the bench sweeps every code on every pin in both edge directions.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_ANY  = 2'd3
  } edge_sel_e;

  localparam int REG_CTRL     = 0;
  localparam int REG_FLAG     = 1;
  localparam int REG_EN       = 2;
  localparam int REG_CAP_BASE = 4;

  // Decide whether a sampled transition prev->cur is wanted by code.
  function automatic logic edge_match(input logic [1:0] code,
                                      input logic prev, input logic cur);
    logic rise;
    logic fall;
    rise = !prev && cur;
    fall = prev && !cur;
    case (edge_sel_e'(code))
      EDG_RISE: edge_match = rise;
      EDG_FALL: edge_match = fall;
      EDG_ANY:  edge_match = rise || fall;
      default:  edge_match = 1'b0;
    endcase
  endfunction

  // Flag update: clear the written ones, then let captures win.
  function automatic logic [7:0] flag_next(input logic [7:0] cur,
                                           input logic [7:0] clr,
                                           input logic [7:0] set);
    flag_next = (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/icap_edge_det.sv
module icap_edge_det
  import icap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] code,
  output logic       chg,
  output logic       hit
);

  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  assign chg = pin ^ pin_q;
  assign hit = edge_match(code, pin_q, pin);

endmodule

// File: rtl/icap_cap_reg.sv
module icap_cap_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= cnt;
  end

endmodule

// File: rtl/icap_regs.sv
module icap_regs
  import icap_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  localparam int CTRL_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_flag,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] hit,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] flag_q
);

  logic [7:0] clr_mask;
  logic [7:0] set_mask;
  logic [7:0] upd;

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    if (wr_flag) clr_mask[NUM_CH-1:0] = wdata[NUM_CH-1:0];
    set_mask[NUM_CH-1:0] = hit;
    upd = flag_next({{(8-NUM_CH){1'b0}}, flag_q}, clr_mask, set_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_en)   en_q   <= wdata[NUM_CH-1:0];
      flag_q <= upd[NUM_CH-1:0];
    end
  end

endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CTRL_W = 2 * NUM_CH,
  localparam int CAP_BYTES = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] pin_in,
  input  logic [CNT_W-1:0]  timer_cnt,
  output logic              irq
);

  logic [NUM_CH-1:0]       hit;
  logic [NUM_CH-1:0]       chg;
  logic [CTRL_W-1:0]       ctrl_q;
  logic [NUM_CH-1:0]       en_q;
  logic [NUM_CH-1:0]       flag_q;
  logic [CNT_W-1:0]        cap_q [NUM_CH];
  logic [NUM_CH*CNT_W-1:0] cap_flat;
  logic                    wr_ctrl;
  logic                    wr_flag;
  logic                    wr_en;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_flag = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_FLAG));
  assign wr_en   = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_EN));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    icap_edge_det u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_in[i]),
      .code (ctrl_q[2*i +: 2]),
      .chg  (chg[i]),
      .hit  (hit[i])
    );

    icap_cap_reg #(.CNT_W(CNT_W)) u_cap (
      .clk  (clk),
      .rst_n(rst_n),
      .load (hit[i]),
      .cnt  (timer_cnt),
      .q    (cap_q[i])
    );

    assign cap_flat[i*CNT_W +: CNT_W] = cap_q[i];
  end

  icap_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .wr_flag(wr_flag),
    .wr_en  (wr_en),
    .wdata  (bus_wdata),
    .hit    (hit),
    .ctrl_q (ctrl_q),
    .en_q   (en_q),
    .flag_q (flag_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(REG_CTRL)) bus_rdata[CTRL_W-1:0] = ctrl_q;
      if (bus_addr == ADDR_W'(REG_FLAG)) bus_rdata[NUM_CH-1:0] = flag_q;
      if (bus_addr == ADDR_W'(REG_EN))   bus_rdata[NUM_CH-1:0] = en_q;
      for (int c = 0; c < NUM_CH; c++) begin
        for (int b = 0; b < CAP_BYTES; b++) begin
          if (bus_addr == ADDR_W'(REG_CAP_BASE + c*CAP_BYTES + b))
            bus_rdata = cap_q[c][b*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign irq = |(flag_q & en_q);

endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_sel,
  input logic                    bus_wr,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [NUM_CH-1:0]       pin_in,
  input logic [CNT_W-1:0]        timer_cnt,
  input logic                    irq,
  input logic [NUM_CH-1:0]       hit,
  input logic [NUM_CH-1:0]       flag_q,
  input logic [NUM_CH-1:0]       en_q,
  input logic [NUM_CH*CNT_W-1:0] cap_flat
);

  logic flag_wr;
  logic en_wr;
  assign flag_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(1));
  assign en_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (irq == 1'b0 && flag_q == '0 && en_q == '0)
        else $error("R1: state not cleared during reset");
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r3_change_only: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |-> (pin_in[i] != $past(pin_in[i])));

    a_r4_latch_timer: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> (cap_flat[i*CNT_W +: CNT_W] == $past(timer_cnt)));

    a_r8_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[i] |=> $stable(cap_flat[i*CNT_W +: CNT_W]));

    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flag_q[i]);

    a_r6_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && bus_wdata[i] && !hit[i]) |=> !flag_q[i]);

    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[i] && !(flag_wr && bus_wdata[i])) |=> $stable(flag_q[i]));
  end

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|hit) || $past(en_wr)));

endmodule

bind icap_unit icap_unit_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pin_in   (pin_in),
  .timer_cnt(timer_cnt),
  .irq      (irq),
  .hit      (hit),
  .flag_q   (flag_q),
  .en_q     (en_q),
  .cap_flat (cap_flat)
);

// File: tb/tb_icap_unit.sv
`timescale 1ns/1ps
module tb_icap_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [2:0]  pin_in;
  logic [15:0] timer_cnt;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [15:0] exp_cap [3];

  always #2.5 clk = ~clk;

  icap_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .timer_cnt(timer_cnt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_cap(input int ch, output logic [15:0] v);
    logic [7:0] lo;
    logic [7:0] hi;
    rd(4'(4 + 2*ch), lo);
    rd(4'(5 + 2*ch), hi);
    v = {hi, lo};
  endtask

  // Drive a new pin level with a marker timer value for exactly one edge.
  task automatic drive_pin(input int ch, input logic lvl, input logic [15:0] t);
    @(negedge clk);
    pin_in[ch] = lvl; timer_cnt = t;
    @(negedge clk);
    timer_cnt = ~t;
  endtask

  function automatic logic want(input int code, input logic prev, input logic cur);
    if (prev == cur) return 1'b0;
    if (code == 3) return 1'b1;
    if (code == 1) return cur;
    if (code == 2) return !cur;
    return 1'b0;
  endfunction

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = 3'b000; timer_cnt = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 32'd0);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk("R1 reg zero in reset", 32'(d), 32'd0);
    end
    @(negedge clk); rst_n = 1'b1;
    rd(4'd1, d); chk("R1 flags after reset", 32'(d), 32'd0);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    for (int c = 0; c < 3; c++) exp_cap[c] = 16'h0;

    // R2/R4/R5 sweep: every code, every pin, both directions.
    for (int code = 0; code < 4; code++) begin
      for (int ch = 0; ch < 3; ch++) begin
        wr(4'd0, 8'(code << (2*ch)));
        wr(4'd1, 8'h07);
        for (int dir = 0; dir < 2; dir++) begin
          logic lvl;
          logic [15:0] t;
          logic hitx;
          lvl  = (dir == 0);
          t    = 16'(16'h1200 + code*256 + ch*16 + dir);
          hitx = want(code, !lvl, lvl);
          drive_pin(ch, lvl, t);
          if (hitx) exp_cap[ch] = t;
          rd(4'd1, d);
          chk("R2 R5 flag after edge", 32'(d), hitx ? 32'(1 << ch) : 32'd0);
          rd_cap(ch, v);
          chk("R4 R8 captured count", 32'(v), 32'(exp_cap[ch]));
          wr(4'd1, 8'h07);
        end
      end
    end

    // R3: steady pins never capture even with all codes on "either".
    wr(4'd0, 8'h3F);
    wr(4'd1, 8'h07);
    repeat (6) begin
      @(negedge clk); timer_cnt = timer_cnt + 16'd7;
    end
    rd(4'd1, d); chk("R3 steady pins no flag", 32'(d), 32'd0);
    rd_cap(1, v); chk("R3 steady pins cap held", 32'(v), 32'(exp_cap[1]));

    // R6: all pins change together, then partial clears.
    @(negedge clk); pin_in = 3'b111; timer_cnt = 16'hBEEF;
    @(negedge clk); timer_cnt = 16'h0000;
    for (int c = 0; c < 3; c++) exp_cap[c] = 16'hBEEF;
    rd(4'd1, d); chk("R5 all flags", 32'(d), 32'h07);
    rd_cap(2, v); chk("R4 simultaneous capture", 32'(v), 32'hBEEF);
    wr(4'd1, 8'h02);
    rd(4'd1, d); chk("R6 clear middle flag", 32'(d), 32'h05);
    wr(4'd1, 8'h00);
    rd(4'd1, d); chk("R6 zero write keeps", 32'(d), 32'h05);

    // R7: interrupt combination.
    wr(4'd2, 8'h00); chk("R7 no enable no irq", 32'(irq), 32'd0);
    wr(4'd2, 8'h04); chk("R7 enabled flag raises irq", 32'(irq), 32'd1);
    rd(4'd2, d); chk("R7 enable readback", 32'(d), 32'h04);
    wr(4'd1, 8'h04); chk("R7 clear drops irq", 32'(irq), 32'd0);
    wr(4'd2, 8'h02); chk("R7 enable without flag", 32'(irq), 32'd0);
    wr(4'd2, 8'h01); chk("R7 pin0 flag enabled", 32'(irq), 32'd1);

    // R6: clear and capture on pin 0 in the same cycle, set wins.
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h01;
    pin_in[0] = 1'b0; timer_cnt = 16'h5A5A;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; timer_cnt = 16'h0101;
    exp_cap[0] = 16'h5A5A;
    rd(4'd1, d); chk("R6 capture beats clear", 32'(d), 32'h01);
    rd_cap(0, v); chk("R6 capture value with clear", 32'(v), 32'h5A5A);

    // R8: capture registers ignore writes.
    wr(4'd4, 8'hFF); wr(4'd9, 8'h12);
    rd_cap(0, v); chk("R8 cap0 write ignored", 32'(v), 32'h5A5A);
    rd_cap(2, v); chk("R8 cap2 write ignored", 32'(v), 32'hBEEF);

    // R2: upper control bits read zero.
    wr(4'd0, 8'hFF);
    rd(4'd0, d); chk("R2 control readback", 32'(d), 32'h3F);

    // R9: unmapped addresses.
    wr(4'd3, 8'hFF); wr(4'd15, 8'hFF);
    rd(4'd3, d);  chk("R9 addr3 reads zero", 32'(d), 32'd0);
    rd(4'd15, d); chk("R9 addr15 reads zero", 32'(d), 32'd0);
    rd(4'd1, d);  chk("R9 flags untouched", 32'(d), 32'h01);
    rd(4'd2, d);  chk("R9 enable untouched", 32'(d), 32'h01);

    done = 1'b1;
    summary();
  end

endmodule